// File: doc/BRIEF.md
# Configuration Start-up Event Sequencer

This block hands a programmable device over from configuration to user operation. It counts configuration clock pulses from the end of the clear phase and compares that count with a loaded length value. Once the configuration memory also reports full, a five-stage sticky shift chain begins to fill. Three release events are taken from chosen stages of that chain: the device stops pulling its open-drain DONE pin low, the global 3-state on user I/O ends, and the global set/reset of all storage elements ends. A last stage reports that start-up has finished.

Every stage runs on one fabric clock and moves only on qualified pulses. A configuration-clock pulse input sets the first stage. An option bit chooses whether the later stages advance on configuration-clock pulses or on user-clock pulses. In user-clock mode the second stage is the crossing point between the two pulse trains. A second option makes the fourth stage wait until the wired DONE level reads high, so that several devices can hold each other back. Each global output has its own polarity option. Each can also be handed over to a user net once its event has fired. A synchronous clear returns every stage to zero, which drives all outputs back to their configuration-time values.

Top module: `startup_seq`

## Requirements
- R1: While `rst_n` is low, or while `clr_mem` is high at a clock edge, the counter and all five stages become zero. After that edge `done_drive_low`=1, `finished`=0, and `gts_out`=1 and `gsr_out`=1 when the inversion and user-net options are 0.
- R2: The counter adds one on each edge where `cfg_ce`=1. Stage 0 is set at the first edge where `cfg_ce`=1, `mem_full`=1 and the count equals `len_count`. If `mem_full` stays 0, no stage is ever set.
- R3: When `sel_usr_clk`=0, stages 1 to 4 each take the value of the stage below them at every edge where `cfg_ce`=1. They hold at every other edge.
- R4: When `sel_usr_clk`=1, stages 1 to 4 move only at edges where `usr_ce`=1. `cfg_ce` alone does not move them.
- R5: Each event has a 2-bit tap select: 0 picks stage 1, 1 picks stage 2, 2 picks stage 3 and 3 picks stage 4. The event has fired while its tapped stage is 1. `done_drive_low` is 1 exactly while the DONE event has not fired.
- R6: With taps DONE=0, I/O=1, GSR=2 and `cfg_ce` high on every edge, DONE releases first. Global 3-state ends one edge later, and global set/reset ends one edge after that.
- R7: When `sync_done`=1, stage 3 is set only at a step edge where `done_in`=1. Once set, it stays set until clear.
- R8: `finished` equals stage 4.
- R9: `gts_out` = (I/O event not fired, OR (`gts_usr_en` AND `usr_gts`)) XOR `gts_inv`.
- R10: `gsr_out` = (GSR event not fired, OR (`gsr_usr_en` AND `usr_gsr`)) XOR `gsr_inv`. User nets have no effect before their event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_mem | input | 1 | Synchronous active-high clear of counter and stages |
| cfg_ce | input | 1 | Configuration clock pulse qualifier |
| usr_ce | input | 1 | User start-up clock pulse qualifier |
| mem_full | input | 1 | Configuration memory full flag |
| len_count | input | LEN_W | Loaded length count |
| sel_usr_clk | input | 1 | 1: stages 1..4 step on usr_ce |
| sync_done | input | 1 | 1: stage 3 waits for done_in high |
| tap_done | input | 2 | Stage select for DONE release |
| tap_io | input | 2 | Stage select for end of global 3-state |
| tap_gsr | input | 2 | Stage select for end of global set/reset |
| gts_inv | input | 1 | Invert gts_out |
| gsr_inv | input | 1 | Invert gsr_out |
| gts_usr_en | input | 1 | Let usr_gts drive 3-state after release |
| gsr_usr_en | input | 1 | Let usr_gsr drive set/reset after release |
| usr_gts | input | 1 | User net for global 3-state |
| usr_gsr | input | 1 | User net for global set/reset |
| done_in | input | 1 | Level read back from the wired DONE pin |
| done_drive_low | output | 1 | 1: pull DONE pin low |
| gts_out | output | 1 | Global 3-state request |
| gsr_out | output | 1 | Global set/reset request |
| finished | output | 1 | Start-up complete |

## Verification
The hardest state to reach from the ports is a sequence that has passed its start point and is then held at the DONE-input stall while it advances on user-clock pulses. That state needs a length match, a full memory, the user-clock option, a low `done_in` and a sparse `usr_ce` train, all at once. Random episodes draw these options with a fixed seed. They keep `done_in` low for long stretches and `usr_ce` sparse, and a bench model follows every cycle. Directed runs pin the stall, the user-clock hold, the missing memory-full case and the default event order at exact edges.

// File: rtl/startup_pkg.sv
// Shared constants and types for the start-up sequencer.
// Assumes: stage 0 is the start stage, stages 1..4 are tappable.
package startup_pkg;
    localparam int NSTG = 5;           // stages 0..4
    localparam int NEVT = 3;           // release events
    typedef logic [1:0] tap_t;         // 0 -> stage 1 ... 3 -> stage 4
    typedef enum int {EV_DONE = 0, EV_IO = 1, EV_GSR = 2} evt_e;
endpackage

// File: rtl/startup_lencnt.sv
// Counts configuration clock pulses since clear and flags the start condition.
// Assumes: count saturates at all-ones; match needs memory full.
module startup_lencnt #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cfg_ce,
    input  logic             mem_full,
    input  logic [LEN_W-1:0] len_count,
    output logic             match
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic [LEN_W-1:0] cnt;

    // Saturating pulse counter, zeroed by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cfg_ce && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Start condition: length reached and memory full.
    always_comb begin
        match = mem_full && (cnt == len_count);
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !cfg_ce) |=> $stable(cnt)); // R2
endmodule

// File: rtl/startup_shreg.sv
// Sticky five-stage start-up chain. Stage 0 is set on a cfg pulse at match;
// stages 1..4 shift on the selected step pulse; stage 3 may wait on done_in.
// Assumes: all pulses are qualifiers of the single clk.
module startup_shreg
    import startup_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cfg_ce,
    input  logic            usr_ce,
    input  logic            match,
    input  logic            sel_usr_clk,
    input  logic            sync_done,
    input  logic            done_in,
    output logic [NSTG-1:0] q
);
    logic step;
    logic q3_ok;

    // Step pulse for stages 1..4 chosen by the clock option.
    always_comb begin
        step  = sel_usr_clk ? usr_ce : cfg_ce;
        q3_ok = !sync_done || done_in || q[3];
    end

    // Stage 0: set on a cfg pulse while the start condition holds.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q[0] <= 1'b0;
        end else if (cfg_ce && match) begin
            q[0] <= 1'b1;
        end
    end

    // Stages 1..4: shift on the step pulse; stage 3 gated by DONE input.
    generate
        for (genvar k = 1; k < NSTG; k++) begin : g_stg
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    q[k] <= 1'b0;
                end else if (step) begin
                    if (k == 3) q[k] <= q[k-1] && q3_ok;
                    else        q[k] <= q[k-1];
                end
            end
        end
    endgenerate

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0)); // R1
    AST_START_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q[0]) |-> $past(cfg_ce && match)); // R2
    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> (q[NSTG-1:1] == $past(q[NSTG-1:1]))); // R3
    AST_STALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_done && !done_in && !q[3] && !clr) |=> !q[3]); // R7
endmodule

// File: rtl/startup_evt.sv
// One release event: picks a stage by tap, forms the global output with
// optional user-net takeover and polarity. Assumes stg holds stages 1..4.
module startup_evt
    import startup_pkg::*;
(
    input  logic [NSTG-2:0] stg,
    input  tap_t            tap,
    input  logic            inv,
    input  logic            usr_en,
    input  logic            usr_net,
    output logic            fired,
    output logic            gbl
);
    // Event state and output level.
    always_comb begin
        fired = stg[tap];
        gbl   = (!fired || (usr_en && usr_net)) ^ inv;
    end
endmodule

// File: rtl/startup_seq.sv
// Top of the start-up sequencer: counter, stage chain and three events.
// Assumes: clr_mem models the clear/INIT phase; done_in is the wired pin level.
module startup_seq
    import startup_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_mem,
    input  logic             cfg_ce,
    input  logic             usr_ce,
    input  logic             mem_full,
    input  logic [LEN_W-1:0] len_count,
    input  logic             sel_usr_clk,
    input  logic             sync_done,
    input  logic [1:0]       tap_done,
    input  logic [1:0]       tap_io,
    input  logic [1:0]       tap_gsr,
    input  logic             gts_inv,
    input  logic             gsr_inv,
    input  logic             gts_usr_en,
    input  logic             gsr_usr_en,
    input  logic             usr_gts,
    input  logic             usr_gsr,
    input  logic             done_in,
    output logic             done_drive_low,
    output logic             gts_out,
    output logic             gsr_out,
    output logic             finished
);
    logic            match;
    logic [NSTG-1:0] q;
    tap_t            ev_tap  [NEVT];
    logic            ev_inv  [NEVT];
    logic            ev_uen  [NEVT];
    logic            ev_unet [NEVT];
    logic            ev_fire [NEVT];
    logic            ev_gbl  [NEVT];

    startup_lencnt #(.LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_mem), .cfg_ce(cfg_ce),
        .mem_full(mem_full), .len_count(len_count), .match(match)
    );

    startup_shreg u_chain (
        .clk(clk), .rst_n(rst_n), .clr(clr_mem), .cfg_ce(cfg_ce),
        .usr_ce(usr_ce), .match(match), .sel_usr_clk(sel_usr_clk),
        .sync_done(sync_done), .done_in(done_in), .q(q)
    );

    // Per-event option routing; DONE has no polarity or user takeover.
    always_comb begin
        ev_tap[EV_DONE]  = tap_done;  ev_inv[EV_DONE] = 1'b0;
        ev_uen[EV_DONE]  = 1'b0;      ev_unet[EV_DONE] = 1'b0;
        ev_tap[EV_IO]    = tap_io;    ev_inv[EV_IO]   = gts_inv;
        ev_uen[EV_IO]    = gts_usr_en; ev_unet[EV_IO] = usr_gts;
        ev_tap[EV_GSR]   = tap_gsr;   ev_inv[EV_GSR]  = gsr_inv;
        ev_uen[EV_GSR]   = gsr_usr_en; ev_unet[EV_GSR] = usr_gsr;
    end

    generate
        for (genvar e = 0; e < NEVT; e++) begin : g_evt
            startup_evt u_evt (
                .stg(q[NSTG-1:1]), .tap(ev_tap[e]), .inv(ev_inv[e]),
                .usr_en(ev_uen[e]), .usr_net(ev_unet[e]),
                .fired(ev_fire[e]), .gbl(ev_gbl[e])
            );
        end
    endgenerate

    // Output pins.
    always_comb begin
        done_drive_low = ev_gbl[EV_DONE];
        gts_out        = ev_gbl[EV_IO];
        gsr_out        = ev_gbl[EV_GSR];
        finished       = q[NSTG-1];
    end

    AST_FIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (ev_fire[EV_DONE] && ev_fire[EV_IO] && ev_fire[EV_GSR])); // R8
    AST_DONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mem) |=> done_drive_low); // R5
endmodule

// File: tb/sim_startup_seq.sv
module sim_startup_seq;
    localparam int LW = 16;

    logic clk = 1'b0;
    logic rst_n, clr_mem, cfg_ce, usr_ce, mem_full;
    logic [LW-1:0] len_count;
    logic sel_usr_clk, sync_done;
    logic [1:0] tap_done, tap_io, tap_gsr;
    logic gts_inv, gsr_inv, gts_usr_en, gsr_usr_en, usr_gts, usr_gsr, done_in;
    logic done_drive_low, gts_out, gsr_out, finished;

    int n_chk = 0;
    int n_bad = 0;
    int m_cnt;
    logic [4:0] m_q;
    int seed_sink;

    always #10 clk = ~clk;   // 50 MHz

    startup_seq #(.LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_mem(clr_mem), .cfg_ce(cfg_ce),
        .usr_ce(usr_ce), .mem_full(mem_full), .len_count(len_count),
        .sel_usr_clk(sel_usr_clk), .sync_done(sync_done),
        .tap_done(tap_done), .tap_io(tap_io), .tap_gsr(tap_gsr),
        .gts_inv(gts_inv), .gsr_inv(gsr_inv), .gts_usr_en(gts_usr_en),
        .gsr_usr_en(gsr_usr_en), .usr_gts(usr_gts), .usr_gsr(usr_gsr),
        .done_in(done_in), .done_drive_low(done_drive_low),
        .gts_out(gts_out), .gsr_out(gsr_out), .finished(finished)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic fired(input logic [1:0] tap);
        return m_q[tap + 3'd1];
    endfunction

    // Model step taken from the requirements.
    task automatic model_next();
        logic [4:0] n;
        logic step;
        n = m_q;
        if (!rst_n || clr_mem) begin
            m_cnt = 0; m_q = '0; return;
        end
        if (cfg_ce && mem_full && m_cnt == int'(len_count)) n[0] = 1'b1;  // R2
        step = sel_usr_clk ? usr_ce : cfg_ce;                             // R3 R4
        if (step) begin
            n[1] = m_q[0];
            n[2] = m_q[1];
            n[3] = m_q[2] && (!sync_done || done_in || m_q[3]);           // R7
            n[4] = m_q[3];
        end
        if (cfg_ce && m_cnt < 65535) m_cnt++;
        m_q = n;
    endtask

    task automatic compare_all();
        chk("R5 done_drive_low", done_drive_low, !fired(tap_done));
        chk("R9 gts_out", gts_out, (!fired(tap_io) || (gts_usr_en && usr_gts)) ^ gts_inv);
        chk("R10 gsr_out", gsr_out, (!fired(tap_gsr) || (gsr_usr_en && usr_gsr)) ^ gsr_inv);
        chk("R8 finished", finished, m_q[4]);
    endtask

    task automatic cyc();
        model_next();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic defaults();
        clr_mem = 0; cfg_ce = 0; usr_ce = 0; mem_full = 0; len_count = '0;
        sel_usr_clk = 0; sync_done = 0; tap_done = 2'd0; tap_io = 2'd1; tap_gsr = 2'd2;
        gts_inv = 0; gsr_inv = 0; gts_usr_en = 0; gsr_usr_en = 0;
        usr_gts = 0; usr_gsr = 0; done_in = 1;
    endtask

    task automatic do_clear();
        clr_mem = 1; cyc(); clr_mem = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        seed_sink = $urandom(32'h5eed);
        m_cnt = 0; m_q = '0;
        defaults();
        rst_n = 0;
        @(negedge clk);
        cyc(); cyc();
        // R1 reset state
        chk("R1 reset done_drive_low", done_drive_low, 1'b1);
        chk("R1 reset gts_out", gts_out, 1'b1);
        chk("R1 reset gsr_out", gsr_out, 1'b1);
        chk("R1 reset finished", finished, 1'b0);
        rst_n = 1;

        // R6 default order, len 2, cfg_ce every edge
        do_clear();
        len_count = 16'd2; mem_full = 1; cfg_ce = 1;
        cyc(); cyc(); cyc();   // third edge sets stage 0
        chk("R6 done held at start edge", done_drive_low, 1'b1);
        cyc();
        chk("R6 done released first", done_drive_low, 1'b0);
        chk("R6 gts still on", gts_out, 1'b1);
        cyc();
        chk("R6 gts off next", gts_out, 1'b0);
        chk("R6 gsr still on", gsr_out, 1'b1);
        cyc();
        chk("R6 gsr off last", gsr_out, 1'b0);
        chk("R8 not finished yet", finished, 1'b0);
        cyc();
        chk("R8 finished", finished, 1'b1);

        // R1 clear mid-sequence returns to configuration values
        do_clear();
        chk("R1 clear done_drive_low", done_drive_low, 1'b1);
        chk("R1 clear gsr_out", gsr_out, 1'b1);
        chk("R1 clear finished", finished, 1'b0);

        // R2 no start without memory full
        mem_full = 0; len_count = 16'd0;
        for (int i = 0; i < 20; i++) cyc();
        chk("R2 no mem_full no release", done_drive_low, 1'b1);
        chk("R2 no mem_full not finished", finished, 1'b0);

        // R4 user-clock mode ignores cfg_ce for stages 1..4
        do_clear();
        sel_usr_clk = 1; mem_full = 1; len_count = 16'd1; cfg_ce = 1; usr_ce = 0;
        for (int i = 0; i < 10; i++) cyc();
        chk("R4 no usr_ce no release", done_drive_low, 1'b1);
        usr_ce = 1; cyc(); usr_ce = 0;
        chk("R4 usr_ce releases done", done_drive_low, 1'b0);

        // R7 stall on DONE input
        do_clear();
        sel_usr_clk = 0; sync_done = 1; done_in = 0; len_count = 16'd0; cfg_ce = 1;
        for (int i = 0; i < 12; i++) cyc();
        chk("R7 done released under stall", done_drive_low, 1'b0);
        chk("R7 gsr held by stall", gsr_out, 1'b1);
        chk("R7 not finished under stall", finished, 1'b0);
        done_in = 1; cyc();
        chk("R7 gsr ends after done_in", gsr_out, 1'b0);
        cyc();
        chk("R7 finished after release", finished, 1'b1);

        // R10 user net has no effect before release
        do_clear();
        sync_done = 0; gsr_usr_en = 1; usr_gsr = 0; mem_full = 0; cfg_ce = 0;
        cyc();
        chk("R10 user net ignored before release", gsr_out, 1'b1);

        // Random episodes
        for (int ep = 0; ep < 60; ep++) begin
            int mf_at;
            int hold;
            defaults();
            sel_usr_clk = 1'($urandom % 2);
            sync_done   = 1'($urandom % 2);
            tap_done = 2'($urandom % 4); tap_io = 2'($urandom % 4); tap_gsr = 2'($urandom % 4);
            gts_inv = 1'($urandom % 2); gsr_inv = 1'($urandom % 2);
            gts_usr_en = 1'($urandom % 2); gsr_usr_en = 1'($urandom % 2);
            do_clear();
            len_count = 16'($urandom % 10);
            mf_at = $urandom % 15;
            hold = 0;
            for (int c = 0; c < 70; c++) begin
                mem_full = (c >= mf_at);
                cfg_ce   = 1'($urandom % 2);
                usr_ce   = ($urandom % 3 == 0);
                if (hold > 0) begin done_in = 0; hold--; end
                else begin
                    done_in = 1;
                    if ($urandom % 8 == 0) hold = $urandom % 12;
                end
                usr_gts = 1'($urandom % 2); usr_gsr = 1'($urandom % 2);
                if ($urandom % 200 == 0) clr_mem = 1; else clr_mem = 0;
                cyc();
            end
            clr_mem = 0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule